// File: doc/BRIEF.md
# Cell Egress Port with Nibble Mode

This block is the read side of one cell FIFO channel. It pulls 9-bit words from the head of an internal FIFO (the FIFO shows its head word and reports how many words it holds) and drives them onto a single 9-bit lane toward a downstream device. Each cell is a fixed number of words. A cell begins only when the far end signals that it can take a cell and the FIFO holds a whole cell. The first transfer of every cell is marked with a start-of-cell flag.

Two inputs pick the operating style at the start of each cell. The role input picks master or slave. In the master role the port drives an active-low enable and streams the cell on consecutive clocks. In the slave role the port waits for an active-low enable from the far end and advances by one transfer after each clock edge at which that enable is low. The width input picks between full-word transfers and nibble transfers. In nibble mode the same lane carries a 4-bit data path, a ninth-bit line that repeats across both halves of a word, and, in the master role, an output-enable strobe toward the slave device.

Top module: `cell_egress_port`

## Requirements
- R1: With wide_sel high at cell start, each transfer places the whole 9-bit FIFO word on q[8:0].
- R2: With wide_sel low at cell start, each word goes out as two transfers: bits 3:0 on q[3:0] first, then bits 7:4 on q[3:0]; q[6:4] are 0 during nibble transfers.
- R3: In master nibble mode q[7] is 1 during every transfer and returns to 0 in the first cycle without a transfer. In slave nibble mode q[7] is 0.
- R4: In nibble mode q[8] carries bit 8 of the current word in both the low-half and the high-half transfer.
- R5: soc is 1 during the first transfer of a cell and 0 during every other transfer of that cell.
- R6: In the master role en_n_out is 0 in every transfer cycle, and a cell occupies CELL_LEN (wide) or 2*CELL_LEN (nibble) consecutive cycles. Whenever the role input is slave and no master cell is in progress, en_n_out is 1.
- R7: In the slave role, a clock edge at which en_n_in is 0 presents the next transfer on q after that edge. An edge at which en_n_in is 1 leaves q unchanged.
- R8: A cell starts only at an edge where cell_avail is 1 and fifo_count is at least CELL_LEN; otherwise no transfer and no pop occur.
- R9: fifo_pop removes each word exactly once per cell. In nibble mode it fires with the high-half transfer, so both halves come from the same word. A cell drains exactly CELL_LEN words.
- R10: Outside a transfer, q holds its last value (apart from the strobe of R3) and soc is 0.
- R11: mode_master and wide_sel are captured at cell start; changing them mid-cell has no effect on that cell.
- R12: During and right after reset, q is 0, soc is 0, en_n_out is 1 and fifo_pop is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_master | input | 1 | 1 selects master role, 0 slave role (captured at cell start) |
| wide_sel | input | 1 | 1 selects full-word transfers, 0 nibble transfers (captured at cell start) |
| cell_avail | input | 1 | Far end can accept a cell |
| fifo_data | input | 9 | Head word of the internal FIFO |
| fifo_count | input | CNT_W | Words currently held by the internal FIFO |
| fifo_pop | output | 1 | Removes the head word at the clock edge |
| en_n_in | input | 1 | Active-low transfer enable from the far end (slave role) |
| en_n_out | output | 1 | Active-low transfer enable toward the far end (master role) |
| q | output | 9 | Output lane |
| soc | output | 1 | Start-of-cell flag |

## Verification
The lane is driven with random 9-bit words in all four combinations of role and width. Words with bit 8 set and clear show whether the ninth bit repeats across the two halves. Distinct low and high nibbles show whether the halves are ordered correctly and whether the pop comes too early. In slave mode, random gaps in the enable separate true advance-on-enable from free-running output and confirm that the lane holds between transfers. Directed cases hold back cell_avail or keep the FIFO one word short of a cell to test the start gate. Other directed cases queue two cells back to back, and flip the mode inputs in mid-cell to show that the captured mode wins.

// File: rtl/cell_port_pkg.sv
package cell_port_pkg;
   localparam int WORD_W = 9;
   localparam int NIB_W  = 4;

   typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} half_t;

   typedef struct packed {
      logic master;
      logic wide;
   } mode_t;
endpackage

// File: rtl/cell_seq.sv
module cell_seq
   import cell_port_pkg::*;
#(
   parameter int CELL_LEN = 53,
   parameter int CNT_W    = 8,
   localparam int IDX_W   = (CELL_LEN > 1) ? $clog2(CELL_LEN) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mode_t            mode_in,
   input  logic             cell_avail,
   input  logic [CNT_W-1:0] fifo_count,
   input  logic             en_n_in,
   output logic             load,
   output logic             first,
   output half_t            half,
   output mode_t            mode_eff,
   output logic             fifo_pop
);
   logic             active;
   mode_t            mode_lat;
   half_t            half_q;
   logic [IDX_W-1:0] idx;
   logic             ready;
   logic             go;
   logic             last;

   assign ready    = cell_avail && (fifo_count >= CNT_W'(CELL_LEN));
   assign mode_eff = active ? mode_lat : mode_in;
   assign go       = mode_eff.master | ~en_n_in;
   assign first    = !active && ready && go;
   assign load     = (active && go) || first;
   assign half     = half_q;
   assign fifo_pop = load && (mode_eff.wide || (half_q == PH_HIGH));
   assign last     = fifo_pop && (idx == IDX_W'(CELL_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         mode_lat <= '0;
         half_q   <= PH_LOW;
         idx      <= '0;
      end else begin
         if (first) begin
            active   <= 1'b1;
            mode_lat <= mode_in;
         end
         if (load && !mode_eff.wide) begin
            half_q <= (half_q == PH_LOW) ? PH_HIGH : PH_LOW;
         end
         if (fifo_pop) begin
            if (last) begin
               idx    <= '0;
               active <= 1'b0;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/lane_fmt.sv
module lane_fmt
   import cell_port_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   input  half_t             half,
   input  mode_t             mode,
   output logic [WORD_W-1:0] lane
);
   localparam int GAP_LO = NIB_W;
   localparam int GAP_HI = WORD_W - 3;

   genvar b;
   generate
      for (b = 0; b < NIB_W; b++) begin : g_nib
         assign lane[b] = mode.wide ? word[b]
                        : ((half == PH_HIGH) ? word[b + NIB_W] : word[b]);
      end
      for (b = GAP_LO; b <= GAP_HI; b++) begin : g_gap
         assign lane[b] = mode.wide ? word[b] : 1'b0;
      end
   endgenerate

   assign lane[WORD_W-2] = mode.wide ? word[WORD_W-2] : mode.master;
   assign lane[WORD_W-1] = word[WORD_W-1];
endmodule

// File: rtl/out_stage.sv
module out_stage
   import cell_port_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              first,
   input  mode_t             mode,
   input  logic [WORD_W-1:0] lane,
   output logic [WORD_W-1:0] q,
   output logic              soc,
   output logic              en_n_out
);
   logic strobe_q7;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q         <= '0;
         soc       <= 1'b0;
         en_n_out  <= 1'b1;
         strobe_q7 <= 1'b0;
      end else if (load) begin
         q         <= lane;
         soc       <= first;
         en_n_out  <= ~mode.master;
         strobe_q7 <= mode.master & ~mode.wide;
      end else begin
         soc      <= 1'b0;
         en_n_out <= 1'b1;
         if (strobe_q7) begin
            q[WORD_W-2] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cell_egress_port.sv
module cell_egress_port
   import cell_port_pkg::*;
#(
   parameter int CELL_LEN = 53,
   parameter int CNT_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_master,
   input  logic             wide_sel,
   input  logic             cell_avail,
   input  logic [8:0]       fifo_data,
   input  logic [CNT_W-1:0] fifo_count,
   output logic             fifo_pop,
   input  logic             en_n_in,
   output logic             en_n_out,
   output logic [8:0]       q,
   output logic             soc
);
   generate
      if (CELL_LEN < 2) begin : g_len_small
         $error("CELL_LEN must be at least 2");
      end
      if (CELL_LEN >= (1 << CNT_W)) begin : g_cnt_narrow
         $error("CNT_W too narrow to count one cell");
      end
   endgenerate

   mode_t mode_in;
   mode_t mode_eff;
   logic  load;
   logic  first;
   half_t half;
   logic [WORD_W-1:0] lane;

   assign mode_in.master = mode_master;
   assign mode_in.wide   = wide_sel;

   cell_seq #(.CELL_LEN(CELL_LEN), .CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_in    (mode_in),
      .cell_avail (cell_avail),
      .fifo_count (fifo_count),
      .en_n_in    (en_n_in),
      .load       (load),
      .first      (first),
      .half       (half),
      .mode_eff   (mode_eff),
      .fifo_pop   (fifo_pop)
   );

   lane_fmt u_fmt (
      .word (fifo_data),
      .half (half),
      .mode (mode_eff),
      .lane (lane)
   );

   out_stage u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .first    (first),
      .mode     (mode_eff),
      .lane     (lane),
      .q        (q),
      .soc      (soc),
      .en_n_out (en_n_out)
   );
endmodule

// File: rtl/cell_port_chk.sv
module cell_port_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_master,
   input logic             cell_avail,
   input logic [CNT_W-1:0] fifo_count,
   input logic             fifo_pop,
   input logic             en_n_out,
   input logic             soc
);
   // R5
   soc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soc |=> !soc);

   // R8
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soc) |-> $past(cell_avail));

   // R9
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (fifo_count != '0));

   // R6
   burst_soc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_n_out) |-> soc);

   // R6
   slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_master && en_n_out) |=> en_n_out);
endmodule

bind cell_egress_port cell_port_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_master (mode_master),
   .cell_avail  (cell_avail),
   .fifo_count  (fifo_count),
   .fifo_pop    (fifo_pop),
   .en_n_out    (en_n_out),
   .soc         (soc)
);

// File: tb/test_cell_egress_port.sv
module test_cell_egress_port;
   localparam int CLK_PERIOD = 10;
   localparam int L          = 6;
   localparam int CNT_W      = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             mode_master = 1'b1;
   logic             wide_sel = 1'b1;
   logic             cell_avail = 1'b0;
   logic [8:0]       fifo_data;
   logic [CNT_W-1:0] fifo_count;
   logic             fifo_pop;
   logic             en_n_in = 1'b1;
   logic             en_n_out;
   logic [8:0]       q;
   logic             soc;

   logic [8:0] mem [0:255];
   int wr_p = 0;
   int rd_p = 0;
   int n_chk = 0;
   int n_fail = 0;

   assign fifo_data  = mem[rd_p % 256];
   assign fifo_count = CNT_W'(wr_p - rd_p);

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) if (rst_n && fifo_pop) rd_p <= rd_p + 1;

   cell_egress_port #(.CELL_LEN(L), .CNT_W(CNT_W)) i_cell_egress_port (
      .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .wide_sel(wide_sel),
      .cell_avail(cell_avail), .fifo_data(fifo_data), .fifo_count(fifo_count),
      .fifo_pop(fifo_pop), .en_n_in(en_n_in), .en_n_out(en_n_out), .q(q), .soc(soc)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [8:0] exp_item(logic [8:0] w, bit hi, bit master, bit wide);
      if (wide) return w;
      return {w[8], master, 3'b000, hi ? w[7:4] : w[3:0]};
   endfunction

   task automatic push_words(input int n);
      for (int k = 0; k < n; k++) begin
         mem[wr_p % 256] = 9'($urandom);
         wr_p++;
      end
   endtask

   task automatic run_master(input bit wide, input int ncells, input bit flip);
      int base = rd_p;
      int per  = wide ? 1 : 2;
      int n    = ncells * L * per;
      int t    = 0;
      logic [8:0] e;
      logic [8:0] last_q;
      @(negedge clk);
      while (en_n_out && t < 50) begin @(negedge clk); t++; end
      for (int k = 0; k < n; k++) begin
         e = exp_item(mem[(base + k / per) % 256], (k % per) == 1, 1'b1, wide);
         chk(en_n_out == 1'b0, "R6", "master enable low in cell", int'(en_n_out), 0);
         chk(q == e, wide ? "R1" : "R2_R3_R4", "master lane", int'(q), int'(e));
         chk(soc == ((k % (L * per)) == 0), "R5", "soc", int'(soc), int'((k % (L * per)) == 0));
         if (flip && k == 2) begin mode_master = 1'b0; wide_sel = ~wide_sel; end
         @(negedge clk);
      end
      if (flip) begin mode_master = 1'b1; wide_sel = wide; end
      chk(en_n_out == 1'b1, "R6", "enable high after cell", int'(en_n_out), 1);
      chk(soc == 1'b0, "R10", "soc idle", int'(soc), 0);
      chk(rd_p == base + ncells * L, "R9", "words drained", rd_p - base, ncells * L);
      if (!wide) chk(q[7] == 1'b0, "R3", "strobe cleared", int'(q[7]), 0);
      last_q = q;
      repeat (3) @(negedge clk);
      chk(q == last_q && soc == 1'b0, "R10", "lane holds idle", int'(q), int'(last_q));
   endtask

   task automatic run_slave(input bit wide);
      int base;
      int per = wide ? 1 : 2;
      int n   = L * per;
      int k   = 0;
      int t   = 0;
      logic [8:0] e;
      logic [8:0] prev;
      bit en_low;
      @(negedge clk);
      mode_master = 1'b0;
      wide_sel    = wide;
      base        = rd_p;
      push_words(L);
      cell_avail  = 1'b1;
      prev = q;
      while (k < n && t < 500) begin
         en_low  = ($urandom % 10) < 6;
         en_n_in = ~en_low;
         @(posedge clk);
         @(negedge clk);
         t++;
         chk(en_n_out == 1'b1, "R6", "slave enable out high", int'(en_n_out), 1);
         if (en_low) begin
            e = exp_item(mem[(base + k / per) % 256], (k % per) == 1, 1'b0, wide);
            chk(q == e, "R7", "slave transfer", int'(q), int'(e));
            chk(soc == (k == 0), "R5", "slave soc", int'(soc), int'(k == 0));
            k++;
         end else begin
            chk(q == prev && soc == 1'b0, "R7_R10", "slave hold", int'(q), int'(prev));
         end
         prev = q;
      end
      en_n_in = 1'b1;
      chk(rd_p == base + L, "R9", "slave drained", rd_p - base, L);
      mode_master = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R12
      chk(q == 9'd0 && soc == 1'b0, "R12", "reset lane/soc", int'(q), 0);
      chk(en_n_out == 1'b1 && fifo_pop == 1'b0, "R12", "reset enable/pop", int'(en_n_out), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(en_n_out == 1'b1 && soc == 1'b0, "R12", "after reset", int'(en_n_out), 1);

      // R8: one word short of a cell
      push_words(L - 1);
      cell_avail = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(en_n_out == 1'b1 && rd_p == 0, "R8", "short fifo no start", rd_p, 0);
      end
      // R8: cell_avail low
      cell_avail = 1'b0;
      push_words(L + 1);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(en_n_out == 1'b1 && rd_p == 0, "R8", "avail low no start", rd_p, 0);
      end
      cell_avail = 1'b1;
      run_master(1'b1, 2, 1'b0);      // back-to-back wide cells

      wide_sel = 1'b0;
      push_words(L);
      run_master(1'b0, 1, 1'b0);      // master nibble

      // R11: mode flipped mid-cell
      wide_sel = 1'b0;
      push_words(L);
      run_master(1'b0, 1, 1'b1);
      wide_sel = 1'b1;
      push_words(L);
      run_master(1'b1, 1, 1'b1);

      for (int r = 0; r < 4; r++) begin
         bit w = 1'($urandom);
         wide_sel = w;
         push_words(L);
         run_master(w, 1, 1'b0);
      end

      cell_avail = 1'b0;
      run_slave(1'b0);
      cell_avail = 1'b0;
      run_slave(1'b1);
      cell_avail = 1'b0;
      run_slave(1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule